// File: doc/BRIEF.md
# Key-Protected Watchdog with Early Warning

This block is a watchdog peripheral on a simple byte-wide write bus. A shared prescaler turns the core clock into a slow tick. A 16-bit watchdog counter counts that tick down and drives a reset pulse for one clock when it reaches zero. A 24-bit warning timer counts the same tick and raises a sticky interrupt flag before the watchdog runs out. Firmware can then record its state before the reset arrives.

Software arms the watchdog by writing its count, high byte first. Writing the low byte loads the counter and starts it. After that, software restarts it by writing a key byte to a dedicated address. A configuration register decides whether the key must match, and which tick the watchdog counter follows. Its low nibble can also lock the setup registers. Once locked, a stray write cannot retune or halt the watchdog. The key and the warning-control addresses stay writable, so the periodic service routine keeps working.

Top module: `wdt_top`

## Requirements
- R1: After reset the interrupt and reset outputs are low, and nothing counts until software configures the block.
- R2: The prescaler stays stopped until address 0x2 is written. Each such write restarts its divider from zero. Select code (address 0x1, bits 1:0) 0 ticks every clock, 1 every 32 clocks, 2 every 1024 and 3 every 32768.
- R3: The watchdog count is written as a high byte (0x8) and then a low byte (0x9). The low-byte write loads the 16-bit value and starts the counter. The counter decrements once per tick. When it reaches zero, the wdog_rst output is high for exactly one clock.
- R4: With configuration bit 4 set, a write of 0x5C to address 0xA reloads the watchdog from its stored count. Any other byte written there has no effect.
- R5: With configuration bit 4 clear, any byte written to address 0xA reloads the watchdog.
- R6: With configuration bit 5 set, the watchdog counts on the prescaler tick. With it clear, the watchdog counts every clock while the prescaler runs.
- R7: When the configuration low nibble is 0xF, writes to addresses 0x1, 0x2 and 0x4 to 0x9 are ignored. The configuration register (0x0), the warning control (0x3) and the key (0xA) remain writable, and writing 0x00 to the configuration register unlocks.
- R8: The 24-bit warning load value is written at 0x4 (bits 7:0), 0x5 (15:8) and 0x6 (23:16). Writing the warning control (0x3) with bit 1 set reloads the timer and clears the flag; bit 0 enables it. The flag rises L ticks after the reload.
- R9: The warning flag stays set until a warning-control write with bit 1 set. A write with only bit 0 leaves it set.
- R10: Watchdog control bit 0 (address 0x7) suspends counting. The value 0x00 never stops it.
- R11: The watchdog does not count while the prescaler is stopped.
- R12: After expiry the watchdog holds at zero with no further pulse until it is reloaded by key or re-armed. A key reload restarts it from the stored count.
- R13: With a warning load smaller than the watchdog count, started together, the interrupt rises before the reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Write strobe, one byte per clock |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| warn_irq | output | 1 | Sticky early-warning interrupt flag |
| wdog_rst | output | 1 | One-clock reset pulse on watchdog expiry |

## Verification
The assertions rely on the bus carrying at most one write per clock. They also assume the prescaler select is not rewritten in the clock after a tick when checking tick spacing. The bench writes one register per clock through a single write task and sets the select only before starting the prescaler. It never asserts a write during reset, so each expected cycle is counted from the clock edge that took the arming write.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int BYTE_W   = 8;
  localparam int ADDR_W   = 4;
  localparam int WARN_W   = 24;
  localparam int DOG_W    = 16;
  localparam int WARN_BYTES = WARN_W / BYTE_W;

  localparam logic [ADDR_W-1:0] ADDR_CFG      = 4'h0;
  localparam logic [ADDR_W-1:0] ADDR_PRESEL   = 4'h1;
  localparam logic [ADDR_W-1:0] ADDR_TICK_GO  = 4'h2;
  localparam logic [ADDR_W-1:0] ADDR_WARN_CTL = 4'h3;
  localparam logic [ADDR_W-1:0] ADDR_WARN_L0  = 4'h4;
  localparam logic [ADDR_W-1:0] ADDR_DOG_CTL  = 4'h7;
  localparam logic [ADDR_W-1:0] ADDR_DOG_HI   = 4'h8;
  localparam logic [ADDR_W-1:0] ADDR_DOG_LO   = 4'h9;
  localparam logic [ADDR_W-1:0] ADDR_KEY      = 4'hA;

  localparam logic [BYTE_W-1:0] KEY_BYTE = 8'h5C;
  localparam logic [3:0]        LOCK_NIB = 4'hF;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [BYTE_W-1:0]    wdata_i,
  output logic [1:0]           presel_o,
  output logic                 presc_start_o,
  output logic                 key_match_o,
  output logic                 tick_src_o,
  output logic                 halt_o,
  output logic                 warn_we_o,
  output logic                 warn_en_o,
  output logic                 warn_rld_o,
  output logic [WARN_W-1:0]    warn_ld_o,
  output logic                 dog_arm_o,
  output logic [DOG_W-1:0]     dog_arm_val_o,
  output logic                 dog_kick_o,
  output logic [DOG_W-1:0]     dog_kick_val_o
);
  logic [5:0]        cfg_q, cfg_d;
  logic [1:0]        presel_q, presel_d;
  logic              halt_q, halt_d;
  logic [BYTE_W-1:0] hi_q, hi_d, lo_q, lo_d;
  logic [BYTE_W-1:0] wld_q [WARN_BYTES];
  logic [BYTE_W-1:0] wld_d [WARN_BYTES];
  logic              locked, we_ok;

  assign locked = (cfg_q[3:0] == LOCK_NIB);
  assign we_ok  = wr_en_i && !locked;

  always_comb begin
    cfg_d    = cfg_q;
    presel_d = presel_q;
    halt_d   = halt_q;
    hi_d     = hi_q;
    lo_d     = lo_q;
    if (wr_en_i && addr_i == ADDR_CFG) cfg_d = wdata_i[5:0];
    if (we_ok) begin
      case (addr_i)
        ADDR_PRESEL:  presel_d = wdata_i[1:0];
        ADDR_DOG_CTL: halt_d   = wdata_i[0];
        ADDR_DOG_HI:  hi_d     = wdata_i;
        ADDR_DOG_LO:  lo_d     = wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      presel_q <= '0;
      halt_q   <= 1'b0;
      hi_q     <= '0;
      lo_q     <= '0;
    end else begin
      cfg_q    <= cfg_d;
      presel_q <= presel_d;
      halt_q   <= halt_d;
      hi_q     <= hi_d;
      lo_q     <= lo_d;
    end
  end

  for (genvar b = 0; b < WARN_BYTES; b++) begin : g_wld
    localparam logic [ADDR_W-1:0] BYTE_ADDR = ADDR_WARN_L0 + ADDR_W'(b);
    always_comb begin
      wld_d[b] = wld_q[b];
      if (we_ok && addr_i == BYTE_ADDR) wld_d[b] = wdata_i;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wld_q[b] <= '0;
      else        wld_q[b] <= wld_d[b];
    end
    assign warn_ld_o[b*BYTE_W +: BYTE_W] = wld_q[b];
  end

  assign presel_o       = presel_q;
  assign key_match_o    = cfg_q[4];
  assign tick_src_o     = cfg_q[5];
  assign halt_o         = halt_q;
  assign presc_start_o  = we_ok && (addr_i == ADDR_TICK_GO);
  assign warn_we_o      = wr_en_i && (addr_i == ADDR_WARN_CTL);
  assign warn_en_o      = wdata_i[0];
  assign warn_rld_o     = wdata_i[1];
  assign dog_arm_o      = we_ok && (addr_i == ADDR_DOG_LO);
  assign dog_arm_val_o  = {hi_q, wdata_i};
  assign dog_kick_o     = wr_en_i && (addr_i == ADDR_KEY) &&
                          (!cfg_q[4] || wdata_i == KEY_BYTE);
  assign dog_kick_val_o = {hi_q, lo_q};

  // R7: setup bytes stay put while locked
  assert_locked_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
    locked && wr_en_i && addr_i == ADDR_DOG_HI |=> $stable(hi_q));
  assert_locked_presel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    locked && wr_en_i && addr_i == ADDR_PRESEL |=> $stable(presel_q));
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int RATIO_S1 = 32,
  parameter int RATIO_S2 = 1024,
  parameter int RATIO_S3 = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [1:0] sel_i,
  output logic       tick_o,
  output logic       run_o
);
  localparam int CW = (RATIO_S3 > 1) ? $clog2(RATIO_S3) : 1;

  logic [CW-1:0] pc_q, pc_d, lim;
  logic          run_q, run_d;

  always_comb begin
    case (sel_i)
      2'd1:    lim = CW'(RATIO_S1 - 1);
      2'd2:    lim = CW'(RATIO_S2 - 1);
      2'd3:    lim = CW'(RATIO_S3 - 1);
      default: lim = '0;
    endcase
  end

  assign tick_o = run_q && (pc_q == lim);
  assign run_o  = run_q;

  always_comb begin
    run_d = run_q;
    pc_d  = pc_q;
    if (start_i) begin
      run_d = 1'b1;
      pc_d  = '0;
    end else if (run_q) begin
      pc_d = tick_o ? '0 : pc_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      pc_q  <= '0;
    end else begin
      run_q <= run_d;
      pc_q  <= pc_d;
    end
  end

  // R2: a divided tick is never followed by another tick at the same select
  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o && (sel_i != 2'd0) |=> !tick_o || (sel_i != $past(sel_i)));
endmodule

// File: rtl/wdt_warn_timer.sv
module wdt_warn_timer
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              ctrl_we_i,
  input  logic              ctrl_en_i,
  input  logic              ctrl_rld_i,
  input  logic [WARN_W-1:0] load_i,
  output logic              irq_o
);
  logic [WARN_W-1:0] cnt_q, cnt_d;
  logic              en_q, en_d;
  logic              flag_q, flag_d;

  always_comb begin
    cnt_d  = cnt_q;
    en_d   = en_q;
    flag_d = flag_q;
    if (ctrl_we_i) begin
      en_d = ctrl_en_i;
      if (ctrl_rld_i) begin
        cnt_d  = load_i;
        flag_d = 1'b0;
      end
    end else if (en_q && tick_i) begin
      if (cnt_q <= WARN_W'(1)) begin
        cnt_d  = '0;
        flag_d = 1'b1;
        en_d   = 1'b0;
      end else begin
        cnt_d = cnt_q - WARN_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      en_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      en_q   <= en_d;
      flag_q <= flag_d;
    end
  end

  assign irq_o = flag_q;

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !(ctrl_we_i && ctrl_rld_i) |=> flag_q);
  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we_i && ctrl_rld_i |=> !flag_q);
endmodule

// File: rtl/wdt_dog_counter.sv
module wdt_dog_counter
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             halt_i,
  input  logic             arm_i,
  input  logic [DOG_W-1:0] arm_val_i,
  input  logic             kick_i,
  input  logic [DOG_W-1:0] kick_val_i,
  output logic             pulse_o
);
  logic [DOG_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             armed_q, armed_d;
  logic             pulse_q, pulse_d;
  logic             kick_ok;

  assign kick_ok = kick_i && armed_q;

  always_comb begin
    cnt_d   = cnt_q;
    run_d   = run_q;
    armed_d = armed_q;
    pulse_d = 1'b0;
    if (arm_i) begin
      cnt_d   = arm_val_i;
      run_d   = 1'b1;
      armed_d = 1'b1;
    end else if (kick_ok) begin
      cnt_d = kick_val_i;
      run_d = 1'b1;
    end else if (run_q && tick_i && !halt_i) begin
      if (cnt_q <= DOG_W'(1)) begin
        cnt_d   = '0;
        run_d   = 1'b0;
        pulse_d = 1'b1;
      end else begin
        cnt_d = cnt_q - DOG_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      run_q   <= 1'b0;
      armed_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      run_q   <= run_d;
      armed_q <= armed_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse_o = pulse_q;

  assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);
  assert_no_count_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_i && !kick_ok |=> cnt_q <= $past(cnt_q));
  assert_hold_after_expiry_R12: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q && !arm_i && !kick_ok |=> (cnt_q == '0) && !run_q);
  assert_halt_freezes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halt_i && !arm_i && !kick_ok |=> $stable(cnt_q));
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int PS_RATIO_S1 = 32,
  parameter int PS_RATIO_S2 = 1024,
  parameter int PS_RATIO_S3 = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic              warn_irq,
  output logic              wdog_rst
);
  logic rst_meta, rst_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic [1:0]        presel;
  logic              presc_start, presc_tick, presc_run;
  logic              key_match, tick_src, halt;
  logic              warn_we, warn_en, warn_rld;
  logic [WARN_W-1:0] warn_ld;
  logic              dog_arm, dog_kick, dog_tick;
  logic [DOG_W-1:0]  dog_arm_val, dog_kick_val;

  wdt_regs u_regs (
    .clk            (clk),
    .rst_n          (rst_sync),
    .wr_en_i        (bus_we),
    .addr_i         (bus_addr),
    .wdata_i        (bus_wdata),
    .presel_o       (presel),
    .presc_start_o  (presc_start),
    .key_match_o    (key_match),
    .tick_src_o     (tick_src),
    .halt_o         (halt),
    .warn_we_o      (warn_we),
    .warn_en_o      (warn_en),
    .warn_rld_o     (warn_rld),
    .warn_ld_o      (warn_ld),
    .dog_arm_o      (dog_arm),
    .dog_arm_val_o  (dog_arm_val),
    .dog_kick_o     (dog_kick),
    .dog_kick_val_o (dog_kick_val)
  );

  wdt_prescaler #(
    .RATIO_S1 (PS_RATIO_S1),
    .RATIO_S2 (PS_RATIO_S2),
    .RATIO_S3 (PS_RATIO_S3)
  ) u_presc (
    .clk     (clk),
    .rst_n   (rst_sync),
    .start_i (presc_start),
    .sel_i   (presel),
    .tick_o  (presc_tick),
    .run_o   (presc_run)
  );

  wdt_warn_timer u_warn (
    .clk        (clk),
    .rst_n      (rst_sync),
    .tick_i     (presc_tick),
    .ctrl_we_i  (warn_we),
    .ctrl_en_i  (warn_en),
    .ctrl_rld_i (warn_rld),
    .load_i     (warn_ld),
    .irq_o      (warn_irq)
  );

  assign dog_tick = tick_src ? presc_tick : presc_run;

  wdt_dog_counter u_dog (
    .clk        (clk),
    .rst_n      (rst_sync),
    .tick_i     (dog_tick),
    .halt_i     (halt),
    .arm_i      (dog_arm),
    .arm_val_i  (dog_arm_val),
    .kick_i     (dog_kick),
    .kick_val_i (dog_kick_val),
    .pulse_o    (wdog_rst)
  );

  // R11: no watchdog tick without a running prescaler
  assert_tick_needs_run_R11: assert property (@(posedge clk) disable iff (!rst_sync)
    !presc_run |-> !dog_tick);
  // R4: the key path never fires on a mismatching byte when matching is on
  assert_key_match_R4: assert property (@(posedge clk) disable iff (!rst_sync)
    key_match && bus_we && bus_addr == ADDR_KEY && bus_wdata != KEY_BYTE |-> !dog_kick);
endmodule

// File: tb/tb_wdt_top.sv
module tb_wdt_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       warn_irq, wdog_rst;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int mark;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdt_top dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .warn_irq  (warn_irq),
    .wdog_rst  (wdog_rst)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    bus_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // one write, taken at the next rising edge; mark = cycle count after it
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_we = 1'b1;
    bus_addr = a;
    bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    mark = cyc;
  endtask

  task automatic wait_pulse(input int lim, output int at);
    at = -1;
    for (int i = 0; i < lim; i++) begin
      if (wdog_rst) begin
        at = cyc;
        return;
      end
      @(negedge clk);
    end
  endtask

  task automatic wait_irq(input int lim, output int at);
    at = -1;
    for (int i = 0; i < lim; i++) begin
      if (warn_irq) begin
        at = cyc;
        return;
      end
      @(negedge clk);
    end
  endtask

  task automatic count_pulses(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (wdog_rst) cnt++;
    end
  endtask

  task automatic setup(input logic [7:0] cfg, input logic [1:0] sel);
    wr(4'h0, cfg);
    wr(4'h1, {6'd0, sel});
    wr(4'h2, 8'h00);
  endtask

  task automatic t_reset();
    int n;
    do_reset();
    chk(warn_irq == 1'b0, "R1", "irq after reset", warn_irq, 0);
    chk(wdog_rst == 1'b0, "R1", "pulse after reset", wdog_rst, 0);
    count_pulses(50, n);
    chk(n == 0 && !warn_irq, "R1", "idle pulses", n, 0);
  endtask

  task automatic t_load_hold();
    int at, c, n;
    do_reset();
    setup(8'h30, 2'd0);
    wr(4'h8, 8'h01);
    wr(4'h9, 8'h05);
    c = mark;
    wait_pulse(400, at);
    chk(at == c + 261, "R3", "16-bit expiry cycle", at, c + 261);
    @(negedge clk);
    chk(wdog_rst == 1'b0, "R3", "pulse width", wdog_rst, 0);
    count_pulses(100, n);
    chk(n == 0, "R12", "pulses after expiry", n, 0);
    wr(4'hA, 8'h5C);
    c = mark;
    wait_pulse(400, at);
    chk(at == c + 261, "R12", "restart by key", at, c + 261);
  endtask

  task automatic t_wrong_key();
    int at, c;
    do_reset();
    setup(8'h30, 2'd0);
    wr(4'h8, 8'h00);
    wr(4'h9, 8'd40);
    c = mark;
    repeat (5) @(negedge clk);
    wr(4'hA, 8'hA5);
    wr(4'hA, 8'h5D);
    wait_pulse(100, at);
    chk(at == c + 40, "R4", "wrong key ignored", at, c + 40);
  endtask

  task automatic t_any_key();
    int at, c;
    do_reset();
    setup(8'h20, 2'd0);
    wr(4'h8, 8'h00);
    wr(4'h9, 8'd30);
    repeat (10) @(negedge clk);
    wr(4'hA, 8'h00);
    c = mark;
    wait_pulse(100, at);
    chk(at == c + 30, "R5", "any byte reloads", at, c + 30);
  endtask

  task automatic t_tick_source();
    int at, c;
    do_reset();
    setup(8'h10, 2'd1);
    wr(4'h8, 8'h00);
    wr(4'h9, 8'd25);
    c = mark;
    wait_pulse(200, at);
    chk(at == c + 25, "R6", "clock-rate counting", at, c + 25);
  endtask

  task automatic t_prescale();
    int at, c;
    do_reset();
    wr(4'h0, 8'h30);
    wr(4'h1, 8'h01);
    wr(4'h8, 8'h00);
    wr(4'h9, 8'd3);
    wr(4'h2, 8'h00);
    c = mark;
    wait_pulse(300, at);
    chk(at == c + 96, "R2", "divide by 32", at, c + 96);
    wr(4'h1, 8'h02);
    wr(4'h9, 8'd2);
    wr(4'h2, 8'h00);
    c = mark;
    wait_pulse(3000, at);
    chk(at == c + 2048, "R2", "divide by 1024", at, c + 2048);
  endtask

  task automatic t_stopped();
    int at, c, n;
    do_reset();
    wr(4'h0, 8'h30);
    wr(4'h1, 8'h00);
    wr(4'h9, 8'd5);
    count_pulses(100, n);
    chk(n == 0, "R11", "no count while stopped", n, 0);
    wr(4'h2, 8'h00);
    c = mark;
    wait_pulse(50, at);
    chk(at == c + 5, "R11", "count after start", at, c + 5);
  endtask

  task automatic t_halt();
    int at, c, h, n, rem;
    do_reset();
    setup(8'h30, 2'd0);
    wr(4'h8, 8'h00);
    wr(4'h9, 8'd30);
    c = mark;
    repeat (4) @(negedge clk);
    wr(4'h7, 8'h01);
    h = mark;
    count_pulses(60, n);
    chk(n == 0, "R10", "halted", n, 0);
    wr(4'h7, 8'h00);
    rem = 30 - (h - c);
    c = mark;
    wait_pulse(100, at);
    chk(at == c + rem, "R10", "resume", at, c + rem);
  endtask

  task automatic t_lock();
    int at, c;
    do_reset();
    setup(8'h30, 2'd0);
    wr(4'h8, 8'h00);
    wr(4'h9, 8'd20);
    c = mark;
    wr(4'h0, 8'h3F);
    wr(4'h8, 8'h01);
    wr(4'h9, 8'h05);
    wr(4'h7, 8'h01);
    wr(4'h1, 8'h03);
    wait_pulse(100, at);
    chk(at == c + 20, "R7", "locked writes ignored", at, c + 20);
    wr(4'hA, 8'h5C);
    c = mark;
    wait_pulse(100, at);
    chk(at == c + 20, "R7", "key while locked, count kept", at, c + 20);
    wr(4'h0, 8'h00);
    wr(4'h0, 8'h30);
    wr(4'h9, 8'd7);
    c = mark;
    wait_pulse(100, at);
    chk(at == c + 7, "R7", "unlocked rearm", at, c + 7);
  endtask

  task automatic t_warn();
    int ai, ap, c, w;
    do_reset();
    setup(8'h30, 2'd0);
    wr(4'h4, 8'd10);
    wr(4'h5, 8'h00);
    wr(4'h6, 8'h00);
    wr(4'h8, 8'h00);
    wr(4'h9, 8'd20);
    c = mark;
    wr(4'h3, 8'h03);
    w = mark;
    wait_irq(100, ai);
    chk(ai == w + 10, "R8", "warning cycle", ai, w + 10);
    wait_pulse(100, ap);
    chk(ap == c + 20, "R3", "reset cycle", ap, c + 20);
    chk(ai < ap, "R13", "warning before reset", ai, ap);
    chk(warn_irq == 1'b1, "R9", "flag held", warn_irq, 1);
    wr(4'h3, 8'h01);
    chk(warn_irq == 1'b1, "R9", "enable-only keeps flag", warn_irq, 1);
    wr(4'h3, 8'h03);
    chk(warn_irq == 1'b0, "R9", "flag cleared", warn_irq, 0);
  endtask

  task automatic t_warn_wide();
    int ai, w;
    do_reset();
    setup(8'h30, 2'd0);
    wr(4'h4, 8'h03);
    wr(4'h5, 8'h00);
    wr(4'h6, 8'h01);
    wr(4'h3, 8'h03);
    w = mark;
    wait_irq(70000, ai);
    chk(ai == w + 65539, "R8", "24-bit load", ai, w + 65539);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 190000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_load_hold();
    t_wrong_key();
    t_any_key();
    t_tick_source();
    t_prescale();
    t_stopped();
    t_halt();
    t_lock();
    t_warn();
    t_warn_wide();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule